// File: doc/BRIEF.md
# Split-Region Tagged Duplex Queue

This block is the buffer between an external host bus and an internal processor. It holds two queues that run in opposite directions. The inbound queue carries bytes from the host to the local side, and the outbound queue carries bytes from the local side to the host. Both queues share one storage array. A split register sets where the array is divided between them. The inbound queue owns the low entries, from 0 up to split minus 1. The outbound queue owns the entries from split up to the top. Each entry holds a data byte and a one-bit tag. A tag of 1 marks a stream command and a tag of 0 marks plain data. The tag moves through the queue with its byte and comes out beside it.

Data moves between the two sides without any action from the processor core. Each queue raises a service request. A per-queue mode input sends that request either to an interrupt pin or to a DMA request pin. Two immediate-command registers let the two sides exchange single bytes without going through either queue. There is one register for each direction. Writing a register raises a pending flag at the receiving side, and the receiving side clears the flag with an acknowledge.

Top module: `split_tag_fifo`

## Requirements
- R1: After reset both queues are empty, the split is DEPTH/2 (64), both immediate registers hold 0 with no pending flag, and the overrun, underrun and split-error flags are all 0.
- R2: A split write takes effect only when both queues are empty and the value is not 0. The inbound queue then holds split entries and the outbound queue holds DEPTH minus split entries. Any other split write leaves the split unchanged and sets a sticky split-error flag.
- R3: Bytes and their tags leave a queue in the order they were written. A pop presents the byte and its tag on the read outputs from the clock edge that accepts it, and they hold until the next accepted pop.
- R4: The head-tag output shows the tag of the oldest entry before that entry is read. It is 0 while the queue is empty.
- R5: A push to a queue whose count equals its region size is dropped, and the push sets that queue's sticky overrun flag. Fullness is judged on the count before the clock edge.
- R6: A pop from an empty queue leaves the read data and read tag unchanged, and the pop sets that queue's sticky underrun flag.
- R7: Each queue's pointers wrap inside its own region, and filling one queue does not change the count of the other queue.
- R8: The inbound request is active while the inbound queue is not empty. It appears on the interrupt output when its mode input is 0 and on the DMA output when its mode input is 1.
- R9: The outbound request is active while the outbound queue has room, and it is routed by its own mode input in the same way as R8.
- R10: Writing an immediate register stores the byte and sets the pending flag at the receiving side. An acknowledge clears the flag and keeps the byte. A write in the same cycle as an acknowledge wins.
- R11: A push and a pop accepted on the same queue in the same cycle leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_wr | input | 1 | Request to load a new split value |
| split_val | input | 7 | Split value to load |
| split_cur | output | 7 | Current split (size of the inbound region) |
| split_err | output | 1 | Sticky flag: a split write was rejected |
| in_mode | input | 1 | Inbound request routing: 0 = interrupt, 1 = DMA |
| out_mode | input | 1 | Outbound request routing: 0 = interrupt, 1 = DMA |
| host_push | input | 1 | Host writes one entry into the inbound queue |
| host_push_data | input | 8 | Byte for the inbound push |
| host_push_cmd | input | 1 | Tag for the inbound push (1 = command) |
| local_pop | input | 1 | Local side reads one inbound entry |
| local_pop_data | output | 8 | Last byte read from the inbound queue |
| local_pop_cmd | output | 1 | Tag of the last inbound entry read |
| local_head_cmd | output | 1 | Tag of the oldest inbound entry |
| in_count | output | 8 | Inbound occupancy |
| in_overrun | output | 1 | Sticky inbound overrun flag |
| in_underrun | output | 1 | Sticky inbound underrun flag |
| in_irq | output | 1 | Inbound request on the interrupt output |
| in_dma | output | 1 | Inbound request on the DMA output |
| local_push | input | 1 | Local side writes one entry into the outbound queue |
| local_push_data | input | 8 | Byte for the outbound push |
| local_push_cmd | input | 1 | Tag for the outbound push |
| host_pop | input | 1 | Host reads one outbound entry |
| host_pop_data | output | 8 | Last byte read from the outbound queue |
| host_pop_cmd | output | 1 | Tag of the last outbound entry read |
| host_head_cmd | output | 1 | Tag of the oldest outbound entry |
| out_count | output | 8 | Outbound occupancy |
| out_overrun | output | 1 | Sticky outbound overrun flag |
| out_underrun | output | 1 | Sticky outbound underrun flag |
| out_irq | output | 1 | Outbound request on the interrupt output |
| out_dma | output | 1 | Outbound request on the DMA output |
| h2l_wr | input | 1 | Host writes the host-to-local immediate register |
| h2l_wdata | input | 8 | Byte for the host-to-local immediate register |
| h2l_data | output | 8 | Host-to-local immediate byte |
| h2l_pend | output | 1 | Host-to-local command pending (interrupt to local side) |
| h2l_ack | input | 1 | Local side clears the host-to-local pending flag |
| l2h_wr | input | 1 | Local side writes the local-to-host immediate register |
| l2h_wdata | input | 8 | Byte for the local-to-host immediate register |
| l2h_data | output | 8 | Local-to-host immediate byte |
| l2h_pend | output | 1 | Local-to-host command pending (interrupt to host) |
| l2h_ack | input | 1 | Host clears the local-to-host pending flag |

## Verification
Some rules are checked on every cycle. A queue's count never goes above its region size. A rejected push to a full queue leaves the count where it was. A pop from an empty queue leaves the underrun flag set and the read data held. The split changes only after a cycle in which both queues were empty. Each request reaches at most one of its two outputs, and an accepted inbound push is followed by an active request. An immediate write is followed by its pending flag. Other properties can only be shown by the bench's scenarios: the order of bytes and tags, the pointer wrap inside a shrunken region, the head tag changing between reads, independence between the two regions, and the exact routing of each request for each mode value.

// File: rtl/tq_pkg.sv
package tq_pkg;
    localparam int TQ_DW = 8;

    typedef struct packed {
        logic             cmd;
        logic [TQ_DW-1:0] data;
    } tq_entry_t;

    // Advance an offset by one inside a region of the given size.
    function automatic int unsigned tq_step(input int unsigned off, input int unsigned size);
        return (off + 1 >= size) ? 0 : off + 1;
    endfunction
endpackage

// File: rtl/tq_store.sv
module tq_store
    import tq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we_a,
    input  logic [AW-1:0]   wa_a,
    input  tq_entry_t       wd_a,
    input  logic            we_b,
    input  logic [AW-1:0]   wa_b,
    input  tq_entry_t       wd_b,
    input  logic [AW-1:0]   ra_a,
    output tq_entry_t       rd_a,
    input  logic [AW-1:0]   ra_b,
    output tq_entry_t       rd_b
);
    tq_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) mem[wa_a] <= wd_a;
        if (we_b) mem[wa_b] <= wd_b;
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
endmodule

// File: rtl/tq_ctrl.sv
module tq_ctrl
    import tq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] size,
    input  logic          push,
    input  logic          pop,
    input  tq_entry_t     head,
    output logic          wr_ok,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          overrun,
    output logic          underrun,
    output tq_entry_t     rd_q
);
    logic [AW-1:0] wo, ro;
    logic          rd_ok;

    assign full    = (count == size);
    assign empty   = (count == '0);
    assign wr_ok   = push && !full;
    assign rd_ok   = pop && !empty;
    assign wr_addr = base + wo;
    assign rd_addr = base + ro;

    always_ff @(posedge clk) begin
        if (rst) begin
            wo       <= '0;
            ro       <= '0;
            count    <= '0;
            overrun  <= 1'b0;
            underrun <= 1'b0;
            rd_q     <= '0;
        end else begin
            if (clear) begin
                wo <= '0;
                ro <= '0;
            end else begin
                if (wr_ok) wo <= AW'(tq_step(32'(wo), 32'(size)));
                if (rd_ok) ro <= AW'(tq_step(32'(ro), 32'(size)));
            end
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (rd_ok) rd_q <= head;
            if (push && full) overrun <= 1'b1;
            if (pop && empty) underrun <= 1'b1;
        end
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= size);
    p_full_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)) && overrun);
    p_empty_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> underrun && $stable(rd_q));
endmodule

// File: rtl/tq_imm.sv
module tq_imm
    import tq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [TQ_DW-1:0] wdata,
    input  logic             ack,
    output logic [TQ_DW-1:0] data,
    output logic             pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            pend <= 1'b0;
        end else if (wr) begin
            data <= wdata;
            pend <= 1'b1;
        end else if (ack) begin
            pend <= 1'b0;
        end
    end

    p_imm_raise_r10: assert property (@(posedge clk) disable iff (rst)
        wr |=> pend && (data == $past(wdata)));
endmodule

// File: rtl/split_tag_fifo.sv
module split_tag_fifo
    import tq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             split_wr,
    input  logic [AW-1:0]    split_val,
    output logic [AW-1:0]    split_cur,
    output logic             split_err,
    input  logic             in_mode,
    input  logic             out_mode,
    input  logic             host_push,
    input  logic [TQ_DW-1:0] host_push_data,
    input  logic             host_push_cmd,
    input  logic             local_pop,
    output logic [TQ_DW-1:0] local_pop_data,
    output logic             local_pop_cmd,
    output logic             local_head_cmd,
    output logic [CW-1:0]    in_count,
    output logic             in_overrun,
    output logic             in_underrun,
    output logic             in_irq,
    output logic             in_dma,
    input  logic             local_push,
    input  logic [TQ_DW-1:0] local_push_data,
    input  logic             local_push_cmd,
    input  logic             host_pop,
    output logic [TQ_DW-1:0] host_pop_data,
    output logic             host_pop_cmd,
    output logic             host_head_cmd,
    output logic [CW-1:0]    out_count,
    output logic             out_overrun,
    output logic             out_underrun,
    output logic             out_irq,
    output logic             out_dma,
    input  logic             h2l_wr,
    input  logic [TQ_DW-1:0] h2l_wdata,
    output logic [TQ_DW-1:0] h2l_data,
    output logic             h2l_pend,
    input  logic             h2l_ack,
    input  logic             l2h_wr,
    input  logic [TQ_DW-1:0] l2h_wdata,
    output logic [TQ_DW-1:0] l2h_data,
    output logic             l2h_pend,
    input  logic             l2h_ack
);
    localparam logic [AW-1:0] SPLIT_RST = AW'(DEPTH / 2);

    logic [AW-1:0] split_q;
    logic          split_ok;
    logic [CW-1:0] in_size, out_size;
    logic          in_full, in_empty, out_full, out_empty;
    logic          in_wr_ok, out_wr_ok;
    logic [AW-1:0] in_wa, in_ra, out_wa, out_ra;
    tq_entry_t     in_head, out_head, in_rd, out_rd;
    tq_entry_t     in_wd, out_wd;

    assign split_ok = split_wr && in_empty && out_empty && (split_val != '0);
    assign in_size  = {1'b0, split_q};
    assign out_size = CW'(DEPTH) - in_size;
    assign split_cur = split_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            split_q   <= SPLIT_RST;
            split_err <= 1'b0;
        end else if (split_ok) begin
            split_q <= split_val;
        end else if (split_wr) begin
            split_err <= 1'b1;
        end
    end

    assign in_wd  = '{cmd: host_push_cmd,  data: host_push_data};
    assign out_wd = '{cmd: local_push_cmd, data: local_push_data};

    tq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk),
        .we_a(in_wr_ok),  .wa_a(in_wa),  .wd_a(in_wd),
        .we_b(out_wr_ok), .wa_b(out_wa), .wd_b(out_wd),
        .ra_a(in_ra),  .rd_a(in_head),
        .ra_b(out_ra), .rd_b(out_head)
    );

    tq_ctrl #(.DEPTH(DEPTH)) u_inq (
        .clk(clk), .rst(rst), .clear(split_ok),
        .base('0), .size(in_size),
        .push(host_push), .pop(local_pop), .head(in_head),
        .wr_ok(in_wr_ok), .wr_addr(in_wa), .rd_addr(in_ra),
        .count(in_count), .full(in_full), .empty(in_empty),
        .overrun(in_overrun), .underrun(in_underrun), .rd_q(in_rd)
    );

    tq_ctrl #(.DEPTH(DEPTH)) u_outq (
        .clk(clk), .rst(rst), .clear(split_ok),
        .base(split_q), .size(out_size),
        .push(local_push), .pop(host_pop), .head(out_head),
        .wr_ok(out_wr_ok), .wr_addr(out_wa), .rd_addr(out_ra),
        .count(out_count), .full(out_full), .empty(out_empty),
        .overrun(out_overrun), .underrun(out_underrun), .rd_q(out_rd)
    );

    assign local_pop_data = in_rd.data;
    assign local_pop_cmd  = in_rd.cmd;
    assign host_pop_data  = out_rd.data;
    assign host_pop_cmd   = out_rd.cmd;
    assign local_head_cmd = !in_empty  && in_head.cmd;
    assign host_head_cmd  = !out_empty && out_head.cmd;

    assign in_irq  = !in_empty && !in_mode;
    assign in_dma  = !in_empty &&  in_mode;
    assign out_irq = !out_full && !out_mode;
    assign out_dma = !out_full &&  out_mode;

    tq_imm u_h2l (
        .clk(clk), .rst(rst), .wr(h2l_wr), .wdata(h2l_wdata),
        .ack(h2l_ack), .data(h2l_data), .pend(h2l_pend)
    );

    tq_imm u_l2h (
        .clk(clk), .rst(rst), .wr(l2h_wr), .wdata(l2h_wdata),
        .ack(l2h_ack), .data(l2h_data), .pend(l2h_pend)
    );

    p_split_guard_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(split_q) |-> $past(in_empty && out_empty));
    p_in_route_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({in_irq, in_dma}));
    p_in_req_after_push_r8: assert property (@(posedge clk) disable iff (rst)
        (in_wr_ok && !local_pop) |=> (in_irq || in_dma));
    p_out_route_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_irq, out_dma}));
endmodule

// File: tb/sim_split_tag_fifo.sv
`timescale 1ns/1ps
module sim_split_tag_fifo;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       split_wr = 0, in_mode = 0, out_mode = 0;
    logic [6:0] split_val = '0, split_cur;
    logic       split_err;
    logic       host_push = 0, host_push_cmd = 0, local_pop = 0;
    logic [7:0] host_push_data = '0, local_pop_data;
    logic       local_pop_cmd, local_head_cmd, in_overrun, in_underrun, in_irq, in_dma;
    logic [7:0] in_count, out_count;
    logic       local_push = 0, local_push_cmd = 0, host_pop = 0;
    logic [7:0] local_push_data = '0, host_pop_data;
    logic       host_pop_cmd, host_head_cmd, out_overrun, out_underrun, out_irq, out_dma;
    logic       h2l_wr = 0, h2l_ack = 0, l2h_wr = 0, l2h_ack = 0;
    logic [7:0] h2l_wdata = '0, l2h_wdata = '0, h2l_data, l2h_data;
    logic       h2l_pend, l2h_pend;

    split_tag_fifo u0 (.*);

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic hpush(input logic [7:0] d, input logic c);
        host_push = 1; host_push_data = d; host_push_cmd = c;
        tick(); host_push = 0;
    endtask
    task automatic lpop();
        local_pop = 1; tick(); local_pop = 0;
    endtask
    task automatic lpush(input logic [7:0] d, input logic c);
        local_push = 1; local_push_data = d; local_push_cmd = c;
        tick(); local_push = 0;
    endtask
    task automatic hpop();
        host_pop = 1; tick(); host_pop = 0;
    endtask
    task automatic wsplit(input logic [6:0] v);
        split_wr = 1; split_val = v; tick(); split_wr = 0;
    endtask

    task automatic t_reset();
        chk("R1 in_count", in_count, 0);
        chk("R1 out_count", out_count, 0);
        chk("R1 split", split_cur, 64);
        chk("R1 imm", {h2l_data, l2h_data, h2l_pend, l2h_pend}, 0);
        chk("R1 flags", {split_err, in_overrun, in_underrun, out_overrun, out_underrun}, 0);
        chk("R1 requests", {in_irq, in_dma, out_irq, out_dma}, 4'b0010);
    endtask

    task automatic t_order();
        hpush(8'h11, 0); hpush(8'hA5, 1); hpush(8'h3C, 0);
        chk("R3 count", in_count, 3);
        chk("R4 head tag data", local_head_cmd, 0);
        lpop();
        chk("R3 first", {local_pop_cmd, local_pop_data}, {1'b0, 8'h11});
        chk("R4 head tag cmd", local_head_cmd, 1);
        lpop();
        chk("R3 second", {local_pop_cmd, local_pop_data}, {1'b1, 8'hA5});
        lpop();
        chk("R3 third", {local_pop_cmd, local_pop_data}, {1'b0, 8'h3C});
        chk("R4 head empty", local_head_cmd, 0);
    endtask

    task automatic t_split();
        wsplit(7'd4);
        chk("R2 accepted", split_cur, 4);
        chk("R2 no error", split_err, 0);
        hpush(8'h01, 0);
        wsplit(7'd10);
        chk("R2 rejected busy", split_cur, 4);
        chk("R2 error set", split_err, 1);
        lpop();
        chk("R3 data", local_pop_data, 8'h01);
        for (int i = 0; i < 4; i++) hpush(8'h20 + 8'(i), i[0]);
        chk("R5 full count", in_count, 4);
        chk("R5 no overrun yet", in_overrun, 0);
        chk("R7 other region untouched", out_count, 0);
        hpush(8'h99, 1);
        chk("R5 dropped", in_count, 4);
        chk("R5 overrun", in_overrun, 1);
        for (int i = 0; i < 4; i++) begin
            lpop();
            chk("R7 wrapped order", {local_pop_cmd, local_pop_data}, {i[0], 8'h20 + 8'(i)});
        end
        lpush(8'h70, 1); lpush(8'h71, 0);
        chk("R7 outbound count", out_count, 2);
        chk("R4 host head tag", host_head_cmd, 1);
        hpop();
        chk("R3 outbound first", {host_pop_cmd, host_pop_data}, {1'b1, 8'h70});
        hpop();
        chk("R3 outbound second", {host_pop_cmd, host_pop_data}, {1'b0, 8'h71});
    endtask

    task automatic t_underrun();
        lpop();
        chk("R6 data held", {local_pop_cmd, local_pop_data}, {1'b1, 8'h23});
        chk("R6 underrun", in_underrun, 1);
        chk("R6 other clean", out_underrun, 0);
    endtask

    task automatic t_zero_split();
        wsplit(7'd0);
        chk("R2 zero rejected", split_cur, 4);
    endtask

    task automatic t_req();
        in_mode = 1;
        hpush(8'h55, 0);
        chk("R8 dma route", {in_irq, in_dma}, 2'b01);
        in_mode = 0; #1;
        chk("R8 irq route", {in_irq, in_dma}, 2'b10);
        lpop();
        chk("R8 idle", {in_irq, in_dma}, 2'b00);
        wsplit(7'd120);
        chk("R2 large split", split_cur, 120);
        for (int i = 0; i < 8; i++) lpush(8'h80 + 8'(i), 0);
        chk("R9 full count", out_count, 8);
        chk("R9 no request when full", {out_irq, out_dma}, 2'b00);
        lpush(8'hEE, 0);
        chk("R5 outbound overrun", out_overrun, 1);
        out_mode = 1;
        hpop();
        chk("R9 dma route", {out_irq, out_dma}, 2'b01);
        for (int i = 1; i < 8; i++) hpop();
        chk("R7 outbound drained", {host_pop_data, out_count}, {8'h87, 8'd0});
        out_mode = 0;
    endtask

    task automatic t_concurrent();
        hpush(8'hC0, 0); hpush(8'hC1, 1);
        host_push = 1; host_push_data = 8'hC2; host_push_cmd = 0; local_pop = 1;
        tick(); host_push = 0; local_pop = 0;
        chk("R11 count kept", in_count, 2);
        chk("R11 pop data", local_pop_data, 8'hC0);
    endtask

    task automatic t_imm();
        h2l_wdata = 8'h5A; h2l_wr = 1; tick(); h2l_wr = 0;
        chk("R10 h2l data", {h2l_pend, h2l_data}, {1'b1, 8'h5A});
        chk("R10 l2h idle", l2h_pend, 0);
        h2l_ack = 1; tick(); h2l_ack = 0;
        chk("R10 h2l ack", {h2l_pend, h2l_data}, {1'b0, 8'h5A});
        l2h_wdata = 8'hC3; l2h_wr = 1; l2h_ack = 1; tick(); l2h_wr = 0; l2h_ack = 0;
        chk("R10 write beats ack", {l2h_pend, l2h_data}, {1'b1, 8'hC3});
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        t_reset();
        t_order();
        t_split();
        t_underrun();
        t_zero_split();
        t_req();
        t_concurrent();
        t_imm();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule